// File: doc/BRIEF.md
# Dual-Lane Shared Cache Port Arbiter

This block connects two pipeline lanes to the single access port of a shared L1 cache array. It runs in one of two modes selected by a static mode pin. In split mode the lanes run unrelated instruction or data streams. The arbiter picks one lane's request at a time, alternating fairly between them, and tags each access with a way mask. The mask confines lane 0 to the lower half of the cache ways and lane 1 to the upper half, so neither lane can evict the other's lines.

In lockstep mode both lanes execute the same thread. The arbiter waits until both lanes present a request and then compares them. If they agree, it sends exactly one access to the array and delivers the response to both lanes. If they disagree, it consumes both requests, sends nothing to the array and pulses an error flag.

Every request channel uses valid/ready handshaking. Once a lane raises valid, it must keep valid, address, write data and write enable steady until it sees ready. The array side follows the same rule, with back-pressure through `arr_req_ready`. Responses carry no ready signal: the lanes always accept them. The array must return exactly one response per accepted access, no earlier than the cycle after acceptance. Only one access is outstanding at a time. The mode pin may change only while no request is valid and no access is outstanding.

Top module: `cache_lane_arbiter`

## Requirements
- R1: After reset, no access is presented to the array, both lane readies are low, both response valids are low and the mismatch flag is low.
- R2: In split mode, a lone request from a lane is forwarded with that lane's address, write data and write enable. The way mask has bit i for way i. For lane 0 it has bits 0 to WAYS/2-1 set; for lane 1 it has bits WAYS/2 to WAYS-1 set.
- R3: In split mode, when both lanes are valid, the lane not served by the most recent split-mode access wins. The first tie after reset goes to lane 0.
- R4: In split mode, the array response raises the response valid of only the lane that issued the access, and that lane's read data equals the array read data.
- R5: While an access is outstanding, no new access is presented to the array and no lane sees ready, even if a lane is valid.
- R6: In lockstep mode, a request from only one lane is not forwarded, its ready stays low and no mismatch is flagged.
- R7: In lockstep mode, matching requests from both lanes produce one array access with the way mask all ones. Both lane readies are high in the same cycle as the array handshake.
- R8: In lockstep mode, the array response raises both lane response valids in the same cycle, each carrying the array read data.
- R9: Two lockstep requests mismatch if they differ in address or write enable, or if they are both writes with different write data. Write data is ignored for reads. On a mismatch, both readies are high, no access is presented, and the mismatch flag is high for exactly the next cycle.
- R10: When the array holds ready low, the presented access stays the same and the granted lane's ready stays low, even if the other lane becomes valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lockstep_mode | input | 1 | 1 = lockstep (compare and merge), 0 = split |
| ln0_req_valid | input | 1 | Lane 0 request valid |
| ln0_req_ready | output | 1 | Lane 0 request accepted |
| ln0_addr | input | ADDR_W | Lane 0 address |
| ln0_wdata | input | DATA_W | Lane 0 write data |
| ln0_we | input | 1 | Lane 0 write enable |
| ln0_rsp_valid | output | 1 | Lane 0 response valid |
| ln0_rdata | output | DATA_W | Lane 0 read data |
| ln1_req_valid | input | 1 | Lane 1 request valid |
| ln1_req_ready | output | 1 | Lane 1 request accepted |
| ln1_addr | input | ADDR_W | Lane 1 address |
| ln1_wdata | input | DATA_W | Lane 1 write data |
| ln1_we | input | 1 | Lane 1 write enable |
| ln1_rsp_valid | output | 1 | Lane 1 response valid |
| ln1_rdata | output | DATA_W | Lane 1 read data |
| arr_req_valid | output | 1 | Access presented to the array |
| arr_req_ready | input | 1 | Array accepts the access |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | DATA_W | Array write data |
| arr_we | output | 1 | Array write enable |
| arr_way_mask | output | WAYS | Ways the access may use |
| arr_rsp_valid | input | 1 | Array response valid |
| arr_rdata | input | DATA_W | Array read data |
| lockstep_mismatch | output | 1 | One-cycle pulse when lockstep requests differ |

## Verification
The lockstep comparison is swept over every pairing of four addresses, both write-enable values per lane and two write-data values. This covers read pairs with differing write data, which a comparator that always checked data would wrongly flag. It also covers write pairs that differ only in data, which a comparator that ignored data would wrongly pass. The sweep also checks that the mismatch flag lasts exactly one cycle, so a flag that stuck high would be caught.

Split-mode sweeps repeat the lone-request and tie patterns against a fairness model. A pointer that failed to alternate, or that was updated by lockstep traffic, would hand a tie to the wrong lane. A rival request that arrives during back-pressure would expose a grant that switched lanes while the array was stalled. A request raised while an access is outstanding would catch an arbiter that issued a second access or sent a response to the wrong lane.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Owner record of the outstanding access: bit 0 = lane 0, bit 1 = lane 1
  typedef logic [1:0] owner_t;
  localparam owner_t OWN_BOTH = 2'b11;
endpackage

// File: rtl/cla_rr_pick.sv
module cla_rr_pick (
  input  logic clk,
  input  logic rst_n,
  input  logic req0,
  input  logic req1,
  input  logic adv,
  output logic gnt0,
  output logic gnt1
);
  logic last1_q;   // lane 1 won the most recent handshake
  logic held_q;    // a grant is waiting on back-pressure
  logic held1_q;   // which lane holds that grant
  logic pick1;

  always_comb begin
    if (held_q) pick1 = held1_q;
    else        pick1 = req1 && (!req0 || !last1_q);
    gnt1 = req1 && pick1;
    gnt0 = req0 && !pick1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last1_q <= 1'b1;
      held_q  <= 1'b0;
      held1_q <= 1'b0;
    end else begin
      if (adv) last1_q <= gnt1;
      held_q  <= (gnt0 || gnt1) && !adv;
      held1_q <= gnt1;
    end
  end

  // After lane 0 is served, the next tie goes to lane 1
  assert_tie_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && gnt0) |=> (!(req0 && req1) || gnt1));

  // A stalled grant does not move while its requester stays valid
  assert_grant_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt0 && !adv) |=> (gnt0 || !req0));
endmodule

// File: rtl/cla_lane_cmp.sv
module cla_lane_cmp #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_we,
  output logic              same
);
  logic addr_eq, we_eq, data_eq;
  always_comb begin
    addr_eq = (a_addr == b_addr);
    we_eq   = (a_we == b_we);
    data_eq = (a_wdata == b_wdata);
    same    = addr_eq && we_eq && (!a_we || data_eq);
  end
endmodule

// File: rtl/cla_way_window.sv
module cla_way_window #(
  parameter int WAYS = 4
) (
  output logic [WAYS-1:0] lo_mask,
  output logic [WAYS-1:0] hi_mask,
  output logic [WAYS-1:0] all_mask
);
  localparam int HALF = WAYS / 2;
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign lo_mask[w]  = (w < HALF);
    assign hi_mask[w]  = (w >= HALF);
    assign all_mask[w] = 1'b1;
  end
endmodule

// File: rtl/cache_lane_arbiter.sv
module cache_lane_arbiter #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lockstep_mode,
  input  logic              ln0_req_valid,
  output logic              ln0_req_ready,
  input  logic [ADDR_W-1:0] ln0_addr,
  input  logic [DATA_W-1:0] ln0_wdata,
  input  logic              ln0_we,
  output logic              ln0_rsp_valid,
  output logic [DATA_W-1:0] ln0_rdata,
  input  logic              ln1_req_valid,
  output logic              ln1_req_ready,
  input  logic [ADDR_W-1:0] ln1_addr,
  input  logic [DATA_W-1:0] ln1_wdata,
  input  logic              ln1_we,
  output logic              ln1_rsp_valid,
  output logic [DATA_W-1:0] ln1_rdata,
  output logic              arr_req_valid,
  input  logic              arr_req_ready,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              arr_we,
  output logic [WAYS-1:0]   arr_way_mask,
  input  logic              arr_rsp_valid,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              lockstep_mismatch
);
  import cla_pkg::*;

  logic   busy_q;
  owner_t owner_q;
  logic   err_q;
  logic   idle, both_v, same, lk_issue, lk_drop, fire;
  logic   g0, g1;
  logic [WAYS-1:0] lo_mask, hi_mask, all_mask;

  cla_lane_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .a_addr(ln0_addr), .a_wdata(ln0_wdata), .a_we(ln0_we),
    .b_addr(ln1_addr), .b_wdata(ln1_wdata), .b_we(ln1_we),
    .same(same)
  );

  cla_way_window #(.WAYS(WAYS)) u_ways (
    .lo_mask(lo_mask), .hi_mask(hi_mask), .all_mask(all_mask)
  );

  cla_rr_pick u_rr (
    .clk(clk), .rst_n(rst_n),
    .req0(!lockstep_mode && ln0_req_valid && idle),
    .req1(!lockstep_mode && ln1_req_valid && idle),
    .adv(fire && !lockstep_mode),
    .gnt0(g0), .gnt1(g1)
  );

  always_comb begin
    idle     = !busy_q;
    both_v   = ln0_req_valid && ln1_req_valid;
    lk_issue = lockstep_mode && both_v && same && idle;
    lk_drop  = lockstep_mode && both_v && !same && idle;

    arr_req_valid = lk_issue || g0 || g1;
    arr_addr      = g1 ? ln1_addr  : ln0_addr;
    arr_wdata     = g1 ? ln1_wdata : ln0_wdata;
    arr_we        = g1 ? ln1_we    : ln0_we;
    arr_way_mask  = lockstep_mode ? all_mask : (g1 ? hi_mask : lo_mask);
    fire          = arr_req_valid && arr_req_ready;

    ln0_req_ready = lk_drop || ((lk_issue || g0) && arr_req_ready);
    ln1_req_ready = lk_drop || ((lk_issue || g1) && arr_req_ready);

    ln0_rsp_valid = arr_rsp_valid && busy_q && owner_q[0];
    ln1_rsp_valid = arr_rsp_valid && busy_q && owner_q[1];
    ln0_rdata     = arr_rdata;
    ln1_rdata     = arr_rdata;
    lockstep_mismatch = err_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= lk_drop;
      if (fire) begin
        busy_q  <= 1'b1;
        owner_q <= lockstep_mode ? OWN_BOTH : {g1, g0};
      end else if (arr_rsp_valid) begin
        busy_q <= 1'b0;
      end
    end
  end

  // Lockstep accesses only leave when both lanes agree
  assert_lock_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lockstep_mode && arr_req_valid) |->
      (ln0_addr == ln1_addr && ln0_we == ln1_we && ln0_req_valid && ln1_req_valid));

  // At most one access outstanding
  assert_single_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !arr_req_valid);

  // Split-mode responses reach exactly one lane
  assert_rsp_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rsp_valid && busy_q && !lockstep_mode) |->
      $onehot({ln0_rsp_valid, ln1_rsp_valid}));

  // Lane 0 split-mode accesses stay in the lower ways
  assert_way_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !lockstep_mode && ln0_req_ready) |-> (arr_way_mask == lo_mask));
endmodule

// File: tb/sim_cache_lane_arbiter.sv
module sim_cache_lane_arbiter;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int WAYS   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lockstep_mode = 1'b0;
  logic ln0_req_valid = 1'b0, ln1_req_valid = 1'b0;
  logic ln0_req_ready, ln1_req_ready;
  logic [ADDR_W-1:0] ln0_addr = '0, ln1_addr = '0;
  logic [DATA_W-1:0] ln0_wdata = '0, ln1_wdata = '0;
  logic ln0_we = 1'b0, ln1_we = 1'b0;
  logic ln0_rsp_valid, ln1_rsp_valid;
  logic [DATA_W-1:0] ln0_rdata, ln1_rdata;
  logic arr_req_valid;
  logic arr_req_ready = 1'b0;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_wdata;
  logic arr_we;
  logic [WAYS-1:0] arr_way_mask;
  logic arr_rsp_valid = 1'b0;
  logic [DATA_W-1:0] arr_rdata = '0;
  logic lockstep_mismatch;

  int n_checks = 0;
  int n_fail = 0;
  bit last1 = 1'b1;  // model: lane 1 won the last split-mode access
  localparam logic [WAYS-1:0] LO_M = 4'b0011;
  localparam logic [WAYS-1:0] HI_M = 4'b1100;

  always #(CLK_P/2) clk = ~clk;

  cache_lane_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS)) u0 (
    .clk(clk), .rst_n(rst_n), .lockstep_mode(lockstep_mode),
    .ln0_req_valid(ln0_req_valid), .ln0_req_ready(ln0_req_ready),
    .ln0_addr(ln0_addr), .ln0_wdata(ln0_wdata), .ln0_we(ln0_we),
    .ln0_rsp_valid(ln0_rsp_valid), .ln0_rdata(ln0_rdata),
    .ln1_req_valid(ln1_req_valid), .ln1_req_ready(ln1_req_ready),
    .ln1_addr(ln1_addr), .ln1_wdata(ln1_wdata), .ln1_we(ln1_we),
    .ln1_rsp_valid(ln1_rsp_valid), .ln1_rdata(ln1_rdata),
    .arr_req_valid(arr_req_valid), .arr_req_ready(arr_req_ready),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_we(arr_we),
    .arr_way_mask(arr_way_mask), .arr_rsp_valid(arr_rsp_valid),
    .arr_rdata(arr_rdata), .lockstep_mismatch(lockstep_mismatch)
  );

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Complete an outstanding access with the given read data
  task automatic respond(input logic [DATA_W-1:0] rd, input bit e0, input bit e1, input string tag);
    arr_rsp_valid = 1'b1;
    arr_rdata = rd;
    #1;
    check(ln0_rsp_valid == e0, {tag, " lane0 rsp_valid"}, ln0_rsp_valid, e0);
    check(ln1_rsp_valid == e1, {tag, " lane1 rsp_valid"}, ln1_rsp_valid, e1);
    if (e0) check(ln0_rdata == rd, {tag, " lane0 rdata"}, ln0_rdata, rd);
    if (e1) check(ln1_rdata == rd, {tag, " lane1 rdata"}, ln1_rdata, rd);
    @(negedge clk);
    arr_rsp_valid = 1'b0;
  endtask

  // One split-mode access with the given valid pattern
  task automatic split_access(input bit v0, input bit v1, input logic [ADDR_W-1:0] a0,
                              input logic [ADDR_W-1:0] a1, input bit we0, input bit we1);
    bit w1;
    logic [ADDR_W-1:0] ea;
    logic [DATA_W-1:0] ed;
    bit ewe;
    @(negedge clk);
    ln0_req_valid = v0; ln1_req_valid = v1;
    ln0_addr = a0; ln1_addr = a1;
    ln0_wdata = {8'h10, a0}; ln1_wdata = {8'h20, a1};
    ln0_we = we0; ln1_we = we1;
    arr_req_ready = 1'b1;
    w1 = v1 && (!v0 || !last1);
    ea = w1 ? a1 : a0;
    ed = w1 ? {8'h20, a1} : {8'h10, a0};
    ewe = w1 ? we1 : we0;
    #1;
    check(arr_req_valid == 1'b1, "R2 split arr_req_valid", arr_req_valid, 1);
    check(arr_addr == ea, "R3 split winner address", arr_addr, ea);
    check(arr_wdata == ed && arr_we == ewe, "R2 split wdata/we", {arr_we, arr_wdata}, {ewe, ed});
    check(arr_way_mask == (w1 ? HI_M : LO_M), "R2 split way mask", arr_way_mask, w1 ? HI_M : LO_M);
    check(ln0_req_ready == !w1 && ln1_req_ready == w1, "R3 split readies",
          {ln1_req_ready, ln0_req_ready}, {w1, !w1});
    last1 = w1;
    @(negedge clk);
    ln0_req_valid = 1'b0; ln1_req_valid = 1'b0;
    respond({8'hC0, ea}, !w1, w1, "R4 split");
  endtask

  // One lockstep pair; returns after the pulse window is checked
  task automatic lock_pair(input logic [ADDR_W-1:0] a0, input logic [ADDR_W-1:0] a1,
                           input bit we0, input bit we1,
                           input logic [DATA_W-1:0] d0, input logic [DATA_W-1:0] d1);
    bit m;
    m = (a0 == a1) && (we0 == we1) && (!we0 || d0 == d1);
    @(negedge clk);
    ln0_req_valid = 1'b1; ln1_req_valid = 1'b1;
    ln0_addr = a0; ln1_addr = a1; ln0_we = we0; ln1_we = we1;
    ln0_wdata = d0; ln1_wdata = d1;
    arr_req_ready = 1'b1;
    #1;
    check(arr_req_valid == m, "R9 lockstep compare -> arr_req_valid", arr_req_valid, m);
    check(ln0_req_ready && ln1_req_ready, "R7 lockstep both readies",
          {ln1_req_ready, ln0_req_ready}, 2'b11);
    if (m) check(arr_addr == a0 && arr_way_mask == 4'b1111, "R7 lockstep addr/mask",
                 {arr_way_mask, arr_addr}, {4'b1111, a0});
    @(negedge clk);
    ln0_req_valid = 1'b0; ln1_req_valid = 1'b0;
    #1;
    check(lockstep_mismatch == !m, "R9 mismatch pulse", lockstep_mismatch, !m);
    if (m) respond({8'hD0, a0}, 1'b1, 1'b1, "R8 lockstep");
    else @(negedge clk);
    #1;
    check(lockstep_mismatch == 1'b0, "R9 mismatch pulse length", lockstep_mismatch, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(arr_req_valid == 0, "R1 arr_req_valid after reset", arr_req_valid, 0);
    check(!ln0_req_ready && !ln1_req_ready, "R1 readies after reset", {ln1_req_ready, ln0_req_ready}, 0);
    check(!ln0_rsp_valid && !ln1_rsp_valid, "R1 rsp after reset", {ln1_rsp_valid, ln0_rsp_valid}, 0);
    check(lockstep_mismatch == 0, "R1 mismatch after reset", lockstep_mismatch, 0);

    // R2/R3/R4 split-mode sweep: first a tie (lane 0 wins), then patterns
    split_access(1, 1, 8'h01, 8'h81, 0, 1);
    for (int r = 0; r < 4; r++) begin
      split_access(1, 0, 8'(r), 8'(r + 8'h40), r[0], 0);
      split_access(0, 1, 8'(r), 8'(r + 8'h40), 0, r[0]);
      split_access(1, 1, 8'(r + 8'h10), 8'(r + 8'h50), 1, 0);
      split_access(1, 1, 8'(r + 8'h20), 8'(r + 8'h60), 0, 1);
    end

    // R10 back-pressure: lane 0 stalled; lane 1 arrives while it would win a tie
    split_access(1, 0, 8'h05, 8'h00, 0, 0);
    @(negedge clk);
    ln0_req_valid = 1'b1; ln0_addr = 8'h33; ln0_we = 1'b0; arr_req_ready = 1'b0;
    #1;
    check(arr_req_valid && arr_addr == 8'h33, "R10 stalled access presented", arr_addr, 8'h33);
    check(ln0_req_ready == 0, "R10 lane0 ready low under back-pressure", ln0_req_ready, 0);
    @(negedge clk);
    ln1_req_valid = 1'b1; ln1_addr = 8'h77;
    #1;
    check(arr_req_valid && arr_addr == 8'h33, "R10 grant held against rival", arr_addr, 8'h33);
    check(!ln1_req_ready && !ln0_req_ready, "R10 no ready while stalled", {ln1_req_ready, ln0_req_ready}, 0);
    @(negedge clk);
    arr_req_ready = 1'b1;
    #1;
    check(ln0_req_ready && !ln1_req_ready && arr_addr == 8'h33, "R10 release to held lane",
          {ln1_req_ready, ln0_req_ready}, 2'b01);
    last1 = 1'b0;
    @(negedge clk);
    ln0_req_valid = 1'b0;
    // R5 lane 1 still valid while lane 0's access is outstanding
    #1;
    check(arr_req_valid == 0, "R5 no access while outstanding", arr_req_valid, 1'b0);
    check(ln1_req_ready == 0, "R5 no ready while outstanding", ln1_req_ready, 0);
    respond(16'hBEEF, 1'b1, 1'b0, "R4 after stall");
    #1;
    check(arr_req_valid && arr_addr == 8'h77 && arr_way_mask == HI_M, "R5 queued lane1 issued after response",
          arr_addr, 8'h77);
    last1 = 1'b1;
    @(negedge clk);
    ln1_req_valid = 1'b0;
    respond(16'h1234, 1'b0, 1'b1, "R4 lane1");

    // R6 lockstep with a single valid lane
    lockstep_mode = 1'b1;
    @(negedge clk);
    ln0_req_valid = 1'b1; ln0_addr = 8'h02;
    #1;
    check(arr_req_valid == 0 && ln0_req_ready == 0, "R6 lone lockstep request held",
          {arr_req_valid, ln0_req_ready}, 0);
    @(negedge clk);
    #1;
    check(lockstep_mismatch == 0 && arr_req_valid == 0, "R6 no mismatch on lone request",
          {lockstep_mismatch, arr_req_valid}, 0);
    ln0_req_valid = 1'b0;

    // R7/R8/R9 lockstep comparison sweep
    for (int a0 = 0; a0 < 4; a0++)
      for (int a1 = 0; a1 < 4; a1++)
        for (int we = 0; we < 4; we++)
          for (int d = 0; d < 2; d++)
            lock_pair(8'(a0), 8'(a1), we[0], we[1], 16'h0005, d[0] ? 16'h0006 : 16'h0005);

    // R3 lockstep traffic leaves the split-mode turn unchanged
    lockstep_mode = 1'b0;
    split_access(1, 1, 8'h09, 8'h89, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule